// File: doc/BRIEF.md
# Encoder Position Counter with Edge Latch and Preset

This block holds a 32-bit position count that an upstream quadrature decoder advances through a count-enable strobe and a direction bit. A host controls it through an 8-bit control byte and a 32-bit preset word. The block reports back through an 8-bit status byte and a 32-bit read word. The host can preload the count, and it can snapshot the count into a latch register. A snapshot can be taken on a rising or falling edge of an external latch pin, or on a rising edge of a zero-reference pin. Each snapshot source is armed by turning its enable bit on and fires only once per arming. The active edge can also zero the count.

Both pins pass through a two-flop synchronizer. An edge is seen as a difference between the newest synchronized sample and the one before it. The read word returns either the live count or the latch register, as the host selects. Status and read word are registered, so each lags the state it reports by one clock.

Top module: `enc_latch_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, the count, the latch register, `read_word`, `status_byte` and every armed flag are 0.
- R2: Each cycle with `cnt_en`=1 changes the count by +1 if `cnt_up`=1 and by -1 if `cnt_up`=0, wrapping modulo 2^32.
- R3: A 0-to-1 change of control bit 2 loads `preset_word` into the count. This load wins over a count strobe or a clear in the same cycle. Status bit 2 follows control bit 2 with one cycle of delay.
- R4: With control bit 1 = 0, `read_word` shows the live count. With control bit 1 = 1, it shows the latch register. Status bit 1 echoes control bit 1.
- R5: A 0-to-1 change of control bit 3 arms rising-edge capture. The first rising edge of `latch_pin` after that copies the count into the latch register. Further edges do nothing until the bit is cleared and set again.
- R6: Control bit 4 arms falling-edge capture on `latch_pin` in the same one-shot way. While control bit 3 is 1, falling-edge capture is suppressed, so rising-edge capture has priority.
- R7: A 0-to-1 change of control bit 0 arms capture on the first rising edge of `zero_pin`. That capture sets status bit 0, which stays 1 until control bit 0 returns to 0.
- R8: With control bit 5 = 1, every capture fired through R5, R6 or R7 also clears the count to 0, after the old value has been latched.
- R9: Status bit 4 shows the synchronized level of `latch_pin`, and status bit 3 shows the synchronized level of `zero_pin`. Status bits 7, 6 and 5 are always 0.
- R10: Clearing an enable bit before its edge arrives disarms that source, so a later edge captures nothing.
- R11: A control byte with bit 7 or bit 6 set acts as an all-zero control byte. In that case nothing is armed or preset, and the read word shows the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | Host control byte |
| preset_word | input | 32 | Value loaded on a set-counter request |
| cnt_en | input | 1 | Count strobe from the decoder |
| cnt_up | input | 1 | Direction: 1 increments, 0 decrements |
| latch_pin | input | 1 | External latch input, asynchronous |
| zero_pin | input | 1 | Zero-reference input, asynchronous |
| status_byte | output | 8 | Registered status byte |
| read_word | output | 32 | Registered count or latch value |

## Verification
A preset request and a count strobe can fall in the same cycle. The bench provokes this by raising control bit 2 on the same clock where `cnt_en` is high. It then judges the outcome from the read word: this must equal the preset exactly, with no extra step, while a single strobe afterwards must add one. A latch edge that fires while the count is also being cleared is checked in a similar way: the latched value must be the count from before the clear, and the live count must read zero.

// File: rtl/enc_latch_pkg.sv
package enc_latch_pkg;
  // control byte field positions
  localparam int CB_ZERO_EN   = 0;
  localparam int CB_RD_LATCH  = 1;
  localparam int CB_SET_CNT   = 2;
  localparam int CB_RISE_EN   = 3;
  localparam int CB_FALL_EN   = 4;
  localparam int CB_CLR_LATCH = 5;
  localparam int CB_RSVD      = 6;
  localparam int CB_MODE      = 7;
  // status byte field positions
  localparam int SB_ZERO_VAL  = 0;
  localparam int SB_RD_LATCH  = 1;
  localparam int SB_SET_ACK   = 2;
  localparam int SB_ZERO_LVL  = 3;
  localparam int SB_LATCH_LVL = 4;

  typedef struct packed {
    logic rise;
    logic fall;
    logic zero;
  } cap_sel_t;
endpackage

// File: rtl/enc_sync_edge.sv
module enc_sync_edge #(
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pins,
  output logic [N_PINS-1:0] level,
  output logic [N_PINS-1:0] prev
);
  localparam int DEPTH = SYNC_STAGES + 1;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[DEPTH-2:0], pins[p]};
    end
    assign level[p] = sh[SYNC_STAGES-1];
    assign prev[p]  = sh[SYNC_STAGES];
  end
endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             cnt_en,
  input  logic             cnt_up,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (load)   count <= load_val;
    else if (clear)  count <= '0;
    else if (cnt_en) count <= cnt_up ? count + ONE : count - ONE;
  end

  a_r3_preset_loads: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (!load && !clear && cnt_en && cnt_up) |=> count == CNT_W'($past(count) + ONE));
  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !clear && cnt_en && !cnt_up) |=> count == CNT_W'($past(count) - ONE));
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (!load && clear) |=> count == '0);
endmodule

// File: rtl/enc_latch_unit.sv
module enc_latch_unit
  import enc_latch_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cap_sel_t         enable,
  input  logic             edge_rise,
  input  logic             edge_fall,
  input  logic             zero_rise,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] latch_val,
  output logic             zero_valid,
  output logic             any_fire
);
  cap_sel_t en_q;
  cap_sel_t armed;
  cap_sel_t fire;

  always_comb begin
    fire.rise = armed.rise & edge_rise;
    fire.fall = armed.fall & edge_fall & ~enable.rise;
    fire.zero = armed.zero & zero_rise;
  end
  assign any_fire = |fire;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= enable;
  end

  // one armed flag per source
  for (genvar s = 0; s < 3; s++) begin : g_arm
    always_ff @(posedge clk) begin
      if (rst)                          armed[s] <= 1'b0;
      else if (!enable[s])              armed[s] <= 1'b0;
      else if (enable[s] && !en_q[s])   armed[s] <= 1'b1;
      else if (fire[s])                 armed[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           latch_val <= '0;
    else if (any_fire) latch_val <= cnt_in;
  end

  always_ff @(posedge clk) begin
    if (rst)               zero_valid <= 1'b0;
    else if (!enable.zero) zero_valid <= 1'b0;
    else if (fire.zero)    zero_valid <= 1'b1;
  end

  a_r5_one_shot_rise: assert property (@(posedge clk) disable iff (rst)
    fire.rise |=> !armed.rise);
  a_r6_one_shot_fall: assert property (@(posedge clk) disable iff (rst)
    fire.fall |=> !armed.fall);
  a_r5_capture_value: assert property (@(posedge clk) disable iff (rst)
    any_fire |=> latch_val == $past(cnt_in));
  a_r10_disarm: assert property (@(posedge clk) disable iff (rst)
    !enable.rise |=> !armed.rise);
  a_r7_valid_cleared: assert property (@(posedge clk) disable iff (rst)
    !enable.zero |=> !zero_valid);
  a_r7_valid_set: assert property (@(posedge clk) disable iff (rst)
    fire.zero |=> zero_valid);
endmodule

// File: rtl/enc_latch_ctrl.sv
module enc_latch_ctrl
  import enc_latch_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       ctrl_byte,
  input  logic [CNT_W-1:0] preset_word,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             latch_pin,
  input  logic             zero_pin,
  output logic [7:0]       status_byte,
  output logic [CNT_W-1:0] read_word
);
  localparam int PIN_LATCH = 0;
  localparam int PIN_ZERO  = 1;

  logic [7:0]       ctrl;
  logic             set_q;
  logic             preset_fire;
  logic [1:0]       pin_lvl;
  logic [1:0]       pin_prev;
  logic             l_rise, l_fall, z_rise;
  cap_sel_t         cap_en;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] latch_val;
  logic             zero_valid;
  logic             any_fire;

  // process mode only when the mode and reserved bits are clear
  assign ctrl = (ctrl_byte[CB_MODE] | ctrl_byte[CB_RSVD]) ? 8'h00 : ctrl_byte;

  always_ff @(posedge clk) begin
    if (rst) set_q <= 1'b0;
    else     set_q <= ctrl[CB_SET_CNT];
  end
  assign preset_fire = ctrl[CB_SET_CNT] & ~set_q;

  enc_sync_edge #(.N_PINS(2), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pins  ({zero_pin, latch_pin}),
    .level (pin_lvl),
    .prev  (pin_prev)
  );

  assign l_rise = pin_lvl[PIN_LATCH] & ~pin_prev[PIN_LATCH];
  assign l_fall = ~pin_lvl[PIN_LATCH] & pin_prev[PIN_LATCH];
  assign z_rise = pin_lvl[PIN_ZERO] & ~pin_prev[PIN_ZERO];

  assign cap_en.rise = ctrl[CB_RISE_EN];
  assign cap_en.fall = ctrl[CB_FALL_EN];
  assign cap_en.zero = ctrl[CB_ZERO_EN];

  enc_latch_unit #(.CNT_W(CNT_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .enable     (cap_en),
    .edge_rise  (l_rise),
    .edge_fall  (l_fall),
    .zero_rise  (z_rise),
    .cnt_in     (count),
    .latch_val  (latch_val),
    .zero_valid (zero_valid),
    .any_fire   (any_fire)
  );

  enc_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (preset_fire),
    .load_val (preset_word),
    .clear    (any_fire & ctrl[CB_CLR_LATCH]),
    .cnt_en   (cnt_en),
    .cnt_up   (cnt_up),
    .count    (count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_byte <= '0;
      read_word   <= '0;
    end else begin
      status_byte               <= '0;
      status_byte[SB_ZERO_VAL]  <= zero_valid;
      status_byte[SB_RD_LATCH]  <= ctrl[CB_RD_LATCH];
      status_byte[SB_SET_ACK]   <= ctrl[CB_SET_CNT];
      status_byte[SB_ZERO_LVL]  <= pin_lvl[PIN_ZERO];
      status_byte[SB_LATCH_LVL] <= pin_lvl[PIN_LATCH];
      read_word <= ctrl[CB_RD_LATCH] ? latch_val : count;
    end
  end

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_byte[7:5] == 3'b000);
  a_r3_ack_follows: assert property (@(posedge clk) disable iff (rst)
    preset_fire |=> status_byte[SB_SET_ACK]);
  a_r8_clear_on_capture: assert property (@(posedge clk) disable iff (rst)
    (any_fire && ctrl[CB_CLR_LATCH] && !preset_fire) |=> count == '0);
endmodule

// File: tb/tb_enc_latch_ctrl.sv
module tb_enc_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ctrl_byte = 8'h00;
  logic [31:0] preset_word = '0;
  logic        cnt_en = 1'b0;
  logic        cnt_up = 1'b1;
  logic        latch_pin = 1'b0;
  logic        zero_pin = 1'b0;
  logic [7:0]  status_byte;
  logic [31:0] read_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  enc_latch_ctrl dut (
    .clk(clk), .rst(rst), .ctrl_byte(ctrl_byte), .preset_word(preset_word),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .latch_pin(latch_pin), .zero_pin(zero_pin),
    .status_byte(status_byte), .read_word(read_word)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_preset(input logic [31:0] v);
    preset_word = v;
    ctrl_byte[2] = 1'b1;
    tick(1);
    ctrl_byte[2] = 1'b0;
    tick(2);
  endtask

  task automatic pulse_latch();
    latch_pin = 1'b1; tick(6);
    latch_pin = 1'b0; tick(6);
  endtask

  task automatic pulse_zero();
    zero_pin = 1'b1; tick(6);
    zero_pin = 1'b0; tick(6);
  endtask

  task automatic get_latch(output logic [31:0] v);
    ctrl_byte[1] = 1'b1; tick(2);
    v = read_word;
    ctrl_byte[1] = 1'b0; tick(2);
  endtask

  task automatic get_count(output logic [31:0] v);
    ctrl_byte[1] = 1'b0; tick(2);
    v = read_word;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, prev_latch, a, b, c, exp;
    tick(4);
    // R1 reset state
    check("R1 read during reset", read_word, 0);
    check("R1 status during reset", {24'h0, status_byte}, 0);
    rst = 1'b0;
    tick(1);
    check("R1 read after reset", read_word, 0);
    check("R1 status after reset", {24'h0, status_byte}, 0);
    get_latch(v);
    check("R1 latch after reset", v, 0);

    // R2 count sweeps with wrap
    for (int n = 0; n < 16; n++) begin
      do_preset(32'hFFFF_FFF8);
      cnt_up = 1'b1; cnt_en = 1'b1; tick(n); cnt_en = 1'b0;
      get_count(v);
      check("R2 up wrap", v, 32'hFFFF_FFF8 + n);
    end
    for (int n = 0; n < 16; n++) begin
      do_preset(32'h0000_0005);
      cnt_up = 1'b0; cnt_en = 1'b1; tick(n); cnt_en = 1'b0;
      get_count(v);
      check("R2 down wrap", v, 32'h0000_0005 - n);
    end
    cnt_up = 1'b1;

    // R3 preset collides with count strobe
    preset_word = 32'h1234_5678;
    cnt_en = 1'b1; ctrl_byte[2] = 1'b1;
    check("R3 ack lags by one cycle", {31'h0, status_byte[2]}, 0);
    tick(1);
    cnt_en = 1'b0;
    check("R3 ack follows bit", {31'h0, status_byte[2]}, 1);
    tick(2);
    check("R3 preset wins over count", read_word, 32'h1234_5678);
    ctrl_byte[2] = 1'b0; tick(1);
    check("R3 ack drops", {31'h0, status_byte[2]}, 0);
    cnt_en = 1'b1; tick(1); cnt_en = 1'b0; tick(2);
    check("R3 count after preset", read_word, 32'h1234_5679);

    // R4 status echo of source select
    ctrl_byte[1] = 1'b1; tick(2);
    check("R4 status bit1 set", {31'h0, status_byte[1]}, 1);
    ctrl_byte[1] = 1'b0; tick(2);
    check("R4 status bit1 clear", {31'h0, status_byte[1]}, 0);

    // R5 one-shot rising capture
    do_preset(32'h0000_0100);
    ctrl_byte[3] = 1'b1; tick(3);
    pulse_latch();
    get_latch(v);
    check("R5 first rising edge captures", v, 32'h0000_0100);
    get_count(v);
    check("R4 live count while latch held", v, 32'h0000_0100);
    do_preset(32'h0000_0200);
    pulse_latch();
    get_latch(v);
    check("R5 second edge ignored", v, 32'h0000_0100);
    ctrl_byte[3] = 1'b0; tick(2); ctrl_byte[3] = 1'b1; tick(3);
    pulse_latch();
    get_latch(v);
    check("R5 rearm captures", v, 32'h0000_0200);
    ctrl_byte[3] = 1'b0; tick(3);

    // R10 disarm before edge
    do_preset(32'h0000_0300);
    ctrl_byte[3] = 1'b1; tick(3); ctrl_byte[3] = 1'b0; tick(3);
    pulse_latch();
    get_latch(v);
    check("R10 disarmed no capture", v, 32'h0000_0200);

    // R8 clear on capture
    do_preset(32'h0000_0500);
    ctrl_byte[5] = 1'b1; ctrl_byte[3] = 1'b1; tick(3);
    pulse_latch();
    get_latch(v);
    check("R8 latched before clear", v, 32'h0000_0500);
    get_count(v);
    check("R8 count cleared", v, 0);
    ctrl_byte[5] = 1'b0; ctrl_byte[3] = 1'b0; tick(3);

    // R9 pin levels and reserved bits
    latch_pin = 1'b1; tick(4);
    check("R9 latch level", {29'h0, status_byte[4:3], status_byte[7]}, {29'h0, 3'b100});
    zero_pin = 1'b1; tick(4);
    check("R9 zero level", {29'h0, status_byte[4:3], status_byte[7]}, {29'h0, 3'b110});
    latch_pin = 1'b0; zero_pin = 1'b0; tick(4);
    check("R9 levels low", {24'h0, status_byte}, 0);

    // R11 mode bit set blocks control
    prev_latch = 32'h0000_0500;
    do_preset(32'h0000_0600);
    ctrl_byte = 8'h8A; tick(3);
    pulse_latch();
    check("R11 read shows count", read_word, 32'h0000_0600);
    check("R11 status bit1 zero", {31'h0, status_byte[1]}, 0);
    ctrl_byte = 8'h40; tick(3);
    ctrl_byte = 8'h44; tick(3);
    ctrl_byte = 8'h00; tick(3);
    check("R11 no preset in reserved mode", read_word, 32'h0000_0600);
    get_latch(v);
    check("R11 no capture", v, prev_latch);

    // R5 R6 R7 sweep over enable combinations
    for (int k = 0; k < 8; k++) begin
      bit er, ef, ez;
      er = k[0]; ef = k[1]; ez = k[2];
      ctrl_byte = 8'h00; tick(3);
      a = 32'h1000 + k; b = 32'h2000 + k; c = 32'h3000 + k;
      do_preset(a);
      ctrl_byte[3] = er; ctrl_byte[4] = ef; ctrl_byte[0] = ez; tick(3);
      latch_pin = 1'b1; tick(6);
      do_preset(b);
      latch_pin = 1'b0; tick(6);
      do_preset(c);
      pulse_zero();
      if (ez) exp = c;
      else if (ef && !er) exp = b;
      else if (er) exp = a;
      else exp = prev_latch;
      prev_latch = exp;
      get_latch(v);
      if (ez) check("R7 zero capture", v, exp);
      else if (ef && !er) check("R6 falling capture", v, exp);
      else if (er && ef) check("R6 rising has priority", v, exp);
      else check("R5 rising capture", v, exp);
      check("R7 status bit0", {31'h0, status_byte[0]}, {31'h0, ez});
      get_count(v);
      check("R4 live count after sweep", v, c);
    end
    ctrl_byte = 8'h00; tick(3);
    check("R7 valid cleared on disable", {31'h0, status_byte[0]}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule